// File: doc/BRIEF.md
# Programmable Clock Output Generator

This block drives a single clock output pin from one of two sources. The first is the system clock divided by an even ratio of 2, 4, 6 or 8, always at an exact 50% duty cycle. The second is an external tick that arrives at 16 times a serial port baud rate. In that mode the output toggles once per tick. An 8-bit control register sits on a simple register bus and selects the source and the ratio. The same register enables the output and holds two small extension fields for two prescalers that live outside the block.

Reads of the control register are always allowed. Writes to it are accepted only inside a short window that opens after a two-byte key sequence on a separate key port. Each extension field also has its own software-init input, and the field keeps its value while that input is low. Changes of source or ratio are applied only when a low phase of the output ends, so the pin never carries a shortened high pulse. While the output is disabled the pin is held low.

Top module: `clkout_gen`

## Requirements
- R1: After reset, all eight control bits read 0 and `clk_out` is low.
- R2: A read at the control address returns the register with the enable in bit 0, the ratio select in bits 2:1, prescaler field 0 in bits 4:3, prescaler field 1 in bits 6:5 and the source select in bit 7. A read at any other address returns 0.
- R3: A key write of 8'hAA followed on the very next cycle by a key write of 8'h55 opens a window. A control write is accepted only in one of the 4 cycles that follow the 8'h55 cycle. A control write at any other time leaves the register unchanged. An AA and a 55 that are separated by an idle cycle do not open a window.
- R4: The window closes after its 4 cycles, after one accepted control write, or on any key write that does not complete the sequence.
- R5: With bit 7 = 0 and the output enabled, ratio select code n (0 to 3) gives n+1 cycles high and n+1 cycles low. The resulting division ratios are 2, 4, 6 and 8.
- R6: While bit 0 is 0, `clk_out` is low from the next cycle on. After a write that sets bit 0 is accepted, the first rising edge comes n+2 clock edges after the write's edge, where n is the ratio select code.
- R7: With bit 7 = 1 and the output enabled, `clk_out` toggles on the clock edge that samples `baud_tick` high. It holds its value on every other edge.
- R8: A write changes bits 4:3 only while `psc_init[0]` is 1, and bits 6:5 only while `psc_init[1]` is 1. A write made while the matching input is 0 leaves the field unchanged.
- R9: A new source or ratio is taken over only at the end of a low phase. At that point the output stays low for a further phase of the new setting, so no high pulse is shorter than the old or the new half period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | ADDR_W | Register bus address |
| reg_wdata | input | 8 | Register bus write data |
| reg_we | input | 1 | Register bus write strobe |
| reg_rdata | output | 8 | Register bus read data |
| baud_tick | input | 1 | One-cycle tick at 16x the serial baud rate |
| psc_init | input | 2 | Software-init state of the two prescaler owners |
| key_we | input | 1 | Key port write strobe |
| key_data | input | 8 | Key port write data |
| clk_out | output | 1 | Generated clock output |

## Verification
On every cycle, the bound assertions check a set of local rules. Register contents change only inside an open window, and each prescaler field changes only with its init input high. The window opens only on the confirming key byte and closes on a stray key byte. A disabled output sits low, and in tick mode the output holds between ticks. The remaining behaviours depend on sequences over many cycles and are shown only by the bench's scenarios. These are the exact high and low run lengths per ratio, the latency from enable to the first edge, the boundary cycles of the four-cycle window, and the absence of short pulses while the ratio changes. A cycle-accurate reference model covers all of these.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

   localparam int REG_W = 8;
   localparam int DIV_W = 2;
   localparam int PSC_N = 2;
   localparam int PSC_W = 2;

   typedef struct packed {
      logic                        src;
      logic [PSC_N-1:0][PSC_W-1:0] psc;
      logic [DIV_W-1:0]            div;
      logic                        en;
   } ctrl_t;

endpackage

// File: rtl/clkout_unlock.sv
module clkout_unlock #(
   parameter logic [7:0] KEY_OPEN    = 8'hAA,
   parameter logic [7:0] KEY_CONFIRM = 8'h55,
   parameter int         WIN_LEN     = 4,
   localparam int        WIN_W       = $clog2(WIN_LEN + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       key_we,
   input  logic [7:0] key_data,
   input  logic       consume,
   output logic       win_open
);

   generate
      if (WIN_LEN < 1) begin : g_bad_len
         $error("clkout_unlock: WIN_LEN must be at least 1");
      end
      if (KEY_OPEN == KEY_CONFIRM) begin : g_bad_key
         $error("clkout_unlock: the two key bytes must differ");
      end
   endgenerate

   logic             armed_q;
   logic [WIN_W-1:0] win_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         win_q   <= '0;
      end else begin
         armed_q <= key_we && (key_data == KEY_OPEN);
         if (key_we) begin
            win_q <= (armed_q && (key_data == KEY_CONFIRM)) ? WIN_W'(WIN_LEN) : '0;
         end else if (consume) begin
            win_q <= '0;
         end else if (win_q != '0) begin
            win_q <= win_q - WIN_W'(1);
         end
      end
   end

   assign win_open = (win_q != '0);

endmodule

// File: rtl/clkout_ctrl_reg.sv
module clkout_ctrl_reg
   import clkout_pkg::*;
#(
   parameter int                ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h40,
   parameter bit                READ_FLOP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   input  logic              reg_we,
   input  logic              win_open,
   input  logic [PSC_N-1:0]  psc_init,
   output ctrl_t             ctrl_q,
   output logic              wr_accept,
   output logic [REG_W-1:0]  reg_rdata
);

   ctrl_t                     wr_view;
   logic                      hit;
   logic                      src_q;
   logic                      en_q;
   logic [DIV_W-1:0]          div_q;
   logic [PSC_N*PSC_W-1:0]    psc_flat;

   assign wr_view   = ctrl_t'(reg_wdata);
   assign hit       = (reg_addr == CTRL_ADDR);
   assign wr_accept = reg_we && hit && win_open;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= 1'b0;
         div_q <= '0;
         en_q  <= 1'b0;
      end else if (wr_accept) begin
         src_q <= wr_view.src;
         div_q <= wr_view.div;
         en_q  <= wr_view.en;
      end
   end

   // each extension field has its own write condition
   generate
      for (genvar i = 0; i < PSC_N; i++) begin : g_psc
         logic [PSC_W-1:0] field_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               field_q <= '0;
            end else if (wr_accept && psc_init[i]) begin
               field_q <= wr_view.psc[i];
            end
         end
         assign psc_flat[i*PSC_W +: PSC_W] = field_q;
      end
   endgenerate

   always_comb begin
      ctrl_q     = '0;
      ctrl_q.src = src_q;
      ctrl_q.psc = psc_flat;
      ctrl_q.div = div_q;
      ctrl_q.en  = en_q;
   end

   generate
      if (READ_FLOP) begin : g_rd_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               reg_rdata <= '0;
            end else begin
               reg_rdata <= hit ? REG_W'(ctrl_q) : '0;
            end
         end
      end else begin : g_rd_comb
         assign reg_rdata = hit ? REG_W'(ctrl_q) : '0;
      end
   endgenerate

endmodule

// File: rtl/clkout_divider.sv
module clkout_divider #(
   parameter int DIV_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             cfg_src,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic             baud_tick,
   output logic             clk_out,
   output logic             act_baud
);

   generate
      if (DIV_W < 1) begin : g_bad_w
         $error("clkout_divider: DIV_W must be at least 1");
      end
   endgenerate

   logic             run_q;
   logic             src_q;
   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] cnt_q;
   logic             out_q;
   logic             phase_end;
   logic             cfg_moved;

   // half period is div_q+1 cycles; in tick mode a phase ends on each tick
   assign phase_end = src_q ? baud_tick : (cnt_q == div_q);
   assign cfg_moved = (cfg_src != src_q) || (cfg_div != div_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         src_q <= 1'b0;
         div_q <= '0;
         cnt_q <= '0;
         out_q <= 1'b0;
      end else if (!en) begin
         run_q <= 1'b0;
         cnt_q <= '0;
         out_q <= 1'b0;
      end else if (!run_q) begin
         run_q <= 1'b1;
         src_q <= cfg_src;
         div_q <= cfg_div;
         cnt_q <= '0;
      end else if (phase_end) begin
         cnt_q <= '0;
         if (!out_q && cfg_moved) begin
            src_q <= cfg_src;
            div_q <= cfg_div;
         end else begin
            out_q <= ~out_q;
         end
      end else if (!src_q) begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end

   assign clk_out  = out_q;
   assign act_baud = run_q && src_q;

endmodule

// File: rtl/clkout_gen.sv
module clkout_gen
   import clkout_pkg::*;
#(
   parameter int                ADDR_W      = 8,
   parameter logic [ADDR_W-1:0] CTRL_ADDR   = 'h40,
   parameter logic [7:0]        KEY_OPEN    = 8'hAA,
   parameter logic [7:0]        KEY_CONFIRM = 8'h55,
   parameter int                WIN_LEN     = 4,
   parameter bit                READ_FLOP   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   input  logic              reg_we,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              baud_tick,
   input  logic [PSC_N-1:0]  psc_init,
   input  logic              key_we,
   input  logic [7:0]        key_data,
   output logic              clk_out
);

   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("clkout_gen: ADDR_W must be at least 1");
      end
      if ($bits(ctrl_t) != REG_W) begin : g_bad_layout
         $error("clkout_gen: control layout must fill the register");
      end
   endgenerate

   ctrl_t ctrl_q;
   logic  wr_accept;
   logic  win_open;
   logic  act_baud;

   clkout_unlock #(
      .KEY_OPEN   (KEY_OPEN),
      .KEY_CONFIRM(KEY_CONFIRM),
      .WIN_LEN    (WIN_LEN)
   ) u_unlock (
      .clk     (clk),
      .rst_n   (rst_n),
      .key_we  (key_we),
      .key_data(key_data),
      .consume (wr_accept),
      .win_open(win_open)
   );

   clkout_ctrl_reg #(
      .ADDR_W   (ADDR_W),
      .CTRL_ADDR(CTRL_ADDR),
      .READ_FLOP(READ_FLOP)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_we   (reg_we),
      .win_open (win_open),
      .psc_init (psc_init),
      .ctrl_q   (ctrl_q),
      .wr_accept(wr_accept),
      .reg_rdata(reg_rdata)
   );

   clkout_divider #(
      .DIV_W(DIV_W)
   ) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ctrl_q.en),
      .cfg_src  (ctrl_q.src),
      .cfg_div  (ctrl_q.div),
      .baud_tick(baud_tick),
      .clk_out  (clk_out),
      .act_baud (act_baud)
   );

endmodule

// File: rtl/clkout_gen_chk.sv
module clkout_gen_chk #(
   parameter logic [7:0] KEY_CONFIRM = 8'h55
) (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] ctrl_bits,
   input logic       win_open,
   input logic       key_we,
   input logic [7:0] key_data,
   input logic [1:0] psc_init,
   input logic       baud_tick,
   input logic       act_baud,
   input logic       clk_out
);

   // R1: first sampled cycle out of reset shows a cleared register and a low pin
   a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ctrl_bits == 8'h00) && !clk_out);

   // R3: the register only moves when a window was open
   a_r3_write_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_bits != $past(ctrl_bits)) |-> $past(win_open));

   // R3: a window only opens on the confirming key byte
   a_r3_open_on_confirm: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(win_open) |-> $past(key_we && (key_data == KEY_CONFIRM)));

   // R4: a key byte other than the confirming one shuts the window
   a_r4_stray_key_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (key_we && (key_data != KEY_CONFIRM)) |=> !win_open);

   // R6: disabled means low on the following cycle
   a_r6_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_bits[0] |=> !clk_out);

   // R7: in tick mode the pin holds between ticks
   a_r7_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_bits[0] && act_baud && !baud_tick) |=> $stable(clk_out));

   // R8: each prescaler field changes only under its init input
   a_r8_field0_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_bits[4:3] != $past(ctrl_bits[4:3])) |-> $past(psc_init[0]));

   a_r8_field1_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_bits[6:5] != $past(ctrl_bits[6:5])) |-> $past(psc_init[1]));

endmodule

bind clkout_gen clkout_gen_chk #(
   .KEY_CONFIRM(KEY_CONFIRM)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ctrl_bits(ctrl_q),
   .win_open (win_open),
   .key_we   (key_we),
   .key_data (key_data),
   .psc_init (psc_init),
   .baud_tick(baud_tick),
   .act_baud (act_baud),
   .clk_out  (clk_out)
);

// File: tb/clkout_gen_test.sv
`timescale 1ns/1ps
module clkout_gen_test;

   localparam logic [7:0] ADDR = 8'h40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] reg_addr = ADDR;
   logic [7:0] reg_wdata = 8'h00;
   logic       reg_we = 1'b0;
   logic [7:0] reg_rdata;
   logic       baud_tick = 1'b0;
   logic [1:0] psc_init = 2'b00;
   logic       key_we = 1'b0;
   logic [7:0] key_data = 8'h00;
   logic       clk_out;

   int    total = 0;
   int    bad = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   always #2 clk = ~clk;

   clkout_gen uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_we   (reg_we),
      .reg_rdata(reg_rdata),
      .baud_tick(baud_tick),
      .psc_init (psc_init),
      .key_we   (key_we),
      .key_data (key_data),
      .clk_out  (clk_out)
   );

   // behavioural reference model
   logic [7:0] m_ctrl;
   logic       m_armed, m_run, m_out, m_asrc;
   int         m_win, m_cnt, m_adiv;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ctrl = 8'h00; m_armed = 1'b0; m_win = 0;
         m_run = 1'b0; m_out = 1'b0; m_asrc = 1'b0; m_cnt = 0; m_adiv = 0;
      end else begin
         bit en, nsrc, endp, acc;
         int ndiv;
         en   = m_ctrl[0];
         nsrc = m_ctrl[7];
         ndiv = int'(m_ctrl[2:1]);
         if (!en) begin
            m_run = 1'b0; m_out = 1'b0; m_cnt = 0;
         end else if (!m_run) begin
            m_run = 1'b1; m_asrc = nsrc; m_adiv = ndiv; m_cnt = 0;
         end else begin
            endp = 1'b0;
            if (m_asrc) endp = baud_tick;
            else if (m_cnt == m_adiv) endp = 1'b1;
            else m_cnt = m_cnt + 1;
            if (endp) begin
               m_cnt = 0;
               if (!m_out && (nsrc != m_asrc || ndiv != m_adiv)) begin
                  m_asrc = nsrc; m_adiv = ndiv;
               end else begin
                  m_out = !m_out;
               end
            end
         end
         acc = reg_we && (reg_addr == ADDR) && (m_win > 0);
         if (acc) begin
            m_ctrl[7]   = reg_wdata[7];
            m_ctrl[2:0] = reg_wdata[2:0];
            if (psc_init[0]) m_ctrl[4:3] = reg_wdata[4:3];
            if (psc_init[1]) m_ctrl[6:5] = reg_wdata[6:5];
         end
         if (key_we) m_win = (m_armed && key_data == 8'h55) ? 4 : 0;
         else if (acc) m_win = 0;
         else if (m_win > 0) m_win = m_win - 1;
         m_armed = key_we && (key_data == 8'hAA);
      end
   end

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // compare against the model on every cycle
   always @(negedge clk) begin
      #1;
      if (rst_n && !done) check(clk_out === m_out, cur_req, "clk_out vs model",
                                int'(clk_out), int'(m_out));
   end

   task automatic idle(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic key_now(input logic [7:0] d);
      key_we = 1'b1; key_data = d;
      @(negedge clk);
      key_we = 1'b0;
   endtask

   task automatic unlock();
      key_now(8'hAA);
      key_now(8'h55);
   endtask

   task automatic write_now(input logic [7:0] d);
      reg_addr = ADDR; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic read_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
      reg_addr = a;
      #1;
      check(reg_rdata === exp, tag, "read data", int'(reg_rdata), int'(exp));
      reg_addr = ADDR;
   endtask

   task automatic measure(input int half, input string tag);
      int h, l, g;
      logic p;
      h = 0; l = 0; g = 0;
      p = clk_out;
      @(negedge clk);
      while (!(p == 1'b0 && clk_out == 1'b1) && g < 200) begin
         p = clk_out; @(negedge clk); g++;
      end
      while (clk_out == 1'b1 && h < 50) begin h++; @(negedge clk); end
      while (clk_out == 1'b0 && l < 50) begin l++; @(negedge clk); end
      check(h == half, tag, "high run", h, half);
      check(l == half, tag, "low run", l, half);
   endtask

   task automatic hi_runs(input int cycles, input int lo, input int hi, input string tag);
      int run;
      run = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (clk_out) run++;
         else if (run != 0) begin
            check(run >= lo && run <= hi, tag, "high pulse length", run, lo);
            run = 0;
         end
      end
   endtask

   task automatic en_latency(input int code, input string tag);
      for (int k = 0; k <= code; k++) begin
         @(negedge clk);
         check(clk_out == 1'b0, tag, "low before first edge", int'(clk_out), 0);
      end
      @(negedge clk);
      check(clk_out == 1'b1, tag, "first rising edge", int'(clk_out), 1);
   endtask

   task automatic baud_run(input int n, input int gap);
      logic b;
      for (int i = 0; i < n; i++) begin
         b = clk_out;
         baud_tick = 1'b1;
         @(negedge clk);
         baud_tick = 1'b0;
         check(clk_out == !b, "R7", "toggle on tick", int'(clk_out), int'(!b));
         repeat (gap) begin
            @(negedge clk);
            check(clk_out == !b, "R7", "hold between ticks", int'(clk_out), int'(!b));
         end
      end
   endtask

   initial begin
      #400000;
      if (!done) begin
         done = 1'b1;
         bad++;
         $display("FAIL R1 watchdog: actual=%0d expected=%0d", 1, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      // R1 reset state
      read_chk(ADDR, 8'h00, "R1");
      check(clk_out == 1'b0, "R1", "clk_out after reset", int'(clk_out), 0);
      // R3 write without unlock is dropped
      cur_req = "R3";
      write_now(8'h01);
      read_chk(ADDR, 8'h00, "R3");
      // R6 enable latency, R2 readback, R5 divide by 2
      cur_req = "R6";
      unlock(); write_now(8'h01);
      en_latency(0, "R6");
      read_chk(ADDR, 8'h01, "R2");
      read_chk(8'h41, 8'h00, "R2");
      cur_req = "R5";
      measure(1, "R5");
      cur_req = "R9";
      unlock(); write_now(8'h03);
      idle(12);
      cur_req = "R5";
      measure(2, "R5");
      cur_req = "R9";
      unlock(); write_now(8'h07);
      idle(20);
      cur_req = "R5";
      measure(4, "R5");
      // R9 switch from 8 to 6 without a short pulse
      cur_req = "R9";
      unlock(); write_now(8'h05);
      hi_runs(40, 3, 4, "R9");
      cur_req = "R5";
      measure(3, "R5");
      // R4 / R3 window edges
      cur_req = "R4";
      unlock(); idle(4); write_now(8'h03);
      read_chk(ADDR, 8'h05, "R4");
      unlock(); idle(3); write_now(8'h03);
      read_chk(ADDR, 8'h03, "R3");
      unlock(); key_now(8'h12); write_now(8'h05);
      read_chk(ADDR, 8'h03, "R4");
      unlock(); write_now(8'h05); write_now(8'h07);
      read_chk(ADDR, 8'h05, "R4");
      key_now(8'hAA); idle(1); key_now(8'h55); write_now(8'h07);
      read_chk(ADDR, 8'h05, "R3");
      // R6 disable holds low, then re-enable with divide by 8
      cur_req = "R6";
      unlock(); write_now(8'h00);
      repeat (16) begin
         @(negedge clk);
         check(clk_out == 1'b0, "R6", "low while disabled", int'(clk_out), 0);
      end
      unlock(); write_now(8'h07);
      en_latency(3, "R6");
      // R7 tick source
      cur_req = "R9";
      unlock(); write_now(8'h81);
      idle(20);
      cur_req = "R7";
      check(clk_out == 1'b0, "R7", "idle before ticks", int'(clk_out), 0);
      baud_run(6, 3);
      // R8 prescaler field gating
      cur_req = "R8";
      psc_init = 2'b00;
      unlock(); write_now(8'h78);
      read_chk(ADDR, 8'h00, "R8");
      psc_init = 2'b01;
      unlock(); write_now(8'h78);
      read_chk(ADDR, 8'h18, "R8");
      psc_init = 2'b10;
      unlock(); write_now(8'h78);
      read_chk(ADDR, 8'h78, "R8");
      psc_init = 2'b00;
      unlock(); write_now(8'h01);
      read_chk(ADDR, 8'h79, "R8");
      idle(10);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule